// File: doc/BRIEF.md
# Dual-Direction Mailbox Bypass

This block gives two independently clocked ports a way to hand single 36-bit words to each other without going through any queue. There are two one-word mailboxes. The forward mailbox is written from port A and read on port B. The return mailbox is written from port B and read on port A. A port reaches the mailboxes only while its mailbox-select input is high. In that state its write strobe loads the outgoing mailbox and its read strobe takes the incoming one.

Each mailbox has one occupancy flag, and each clock domain sees its own copy of it. The writing side sees a busy flag. The flag rises the cycle after the write is accepted and stays up until the reader has taken the word. The reading side sees an available flag. It rises a few reader cycles after the write and drops the cycle after the read. The two sides exchange events through toggle registers and multi-stage synchronizers. The stored word does not change while a flag is up, so the data itself needs no synchronizer.

Top module: `mbx_bypass`

## Requirements
- R1: While reset is asserted, all four flags (`a_tx_busy`, `a_rx_avail`, `b_tx_busy`, `b_rx_avail`) read 0, and reset discards any mail that was pending.
- R2: A write with select high, accepted on a rising edge of the writer's clock, raises the writer's busy flag after that edge.
- R3: The reader's available flag stays low until at least two reader clock edges after the write. It is high within eight reader cycles.
- R4: While the available flag is high, the reader's data output equals the accepted word and holds steady.
- R5: A read with select high while mail is available clears the available flag after that reader edge. The writer's busy flag then clears within eight writer cycles.
- R6: A write to a mailbox whose busy flag is set is ignored. The reader later receives the earlier word.
- R7: A write strobe with select low leaves the mailbox untouched, and no flag rises.
- R8: A read strobe with select low leaves the available flag set.
- R9: The return mailbox (port B to port A) behaves like the forward one, with the clocks exchanged.
- R10: Traffic in the two mailboxes at the same time does not interfere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_mb_sel | input | 1 | Port A mailbox select |
| a_wr | input | 1 | Port A write strobe (loads forward mailbox) |
| a_rd | input | 1 | Port A read strobe (takes return mailbox) |
| a_wdata | input | 36 | Port A write word |
| a_rdata | output | 36 | Return mailbox word seen by port A |
| a_tx_busy | output | 1 | Forward mailbox occupied, port A view |
| a_rx_avail | output | 1 | Return mailbox holds mail for port A |
| b_mb_sel | input | 1 | Port B mailbox select |
| b_wr | input | 1 | Port B write strobe (loads return mailbox) |
| b_rd | input | 1 | Port B read strobe (takes forward mailbox) |
| b_wdata | input | 36 | Port B write word |
| b_rdata | output | 36 | Forward mailbox word seen by port B |
| b_tx_busy | output | 1 | Return mailbox occupied, port B view |
| b_rx_avail | output | 1 | Forward mailbox holds mail for port B |

## Verification
The bench checks the available flag right after a write. A design that skipped the synchronizer would show the flag too early, and one whose toggle never crossed would never show it. It writes again while the mailbox is busy and then reads. A design that let the second word through would return it instead of the first. It pulses strobes with select low. A design that ignored select would raise or clear a flag. It runs both mailboxes at once and asserts reset with mail pending, which exposes any shared state between the directions and any flag that survives reset.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_DATA_W  = 36;
    localparam int unsigned MBX_SYNC_NS = 2;

    // Event state held on each side of a mailbox lane
    typedef struct packed {
        logic tgl;
    } mbx_evt_t;
endpackage

// File: rtl/mbx_tog_sync.sv
module mbx_tog_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_lane.sv
module mbx_lane
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W      = MBX_DATA_W,
    parameter int unsigned SYNC_STAGES = MBX_SYNC_NS
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_busy,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_avail
);
    mbx_evt_t          wside_d, wside_q;
    mbx_evt_t          rside_d, rside_q;
    logic [DATA_W-1:0] mail_d, mail_q;
    logic              ack_seen, put_seen;
    logic              accept, take;

    // Writer domain
    mbx_tog_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(wclk), .rst_n(rst_n), .d(rside_q.tgl), .q(ack_seen)
    );

    assign wr_busy = wside_q.tgl ^ ack_seen;
    assign accept  = wr_en & ~wr_busy;

    always_comb begin
        wside_d = wside_q;
        mail_d  = mail_q;
        if (accept) begin
            wside_d.tgl = ~wside_q.tgl;
            mail_d      = wdata;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wside_q <= '0;
            mail_q  <= '0;
        end else begin
            wside_q <= wside_d;
            mail_q  <= mail_d;
        end
    end

    // Reader domain
    mbx_tog_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
        .clk(rclk), .rst_n(rst_n), .d(wside_q.tgl), .q(put_seen)
    );

    assign rd_avail = put_seen ^ rside_q.tgl;
    assign take     = rd_en & rd_avail;
    assign rdata    = mail_q;

    always_comb begin
        rside_d = rside_q;
        if (take) rside_d.tgl = ~rside_q.tgl;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rside_q <= '0;
        else        rside_q <= rside_d;
    end

    // Checks
    p_reset_busy_r1: assert property (@(posedge wclk) !rst_n |-> !wr_busy)
        else $error("busy flag set during reset");
    p_reset_avail_r1: assert property (@(posedge rclk) !rst_n |-> !rd_avail)
        else $error("avail flag set during reset");
    p_busy_after_write_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !wr_busy) |=> wr_busy)
        else $error("accepted write did not raise busy");
    p_data_held_r4: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_avail && $past(rd_avail)) |-> $stable(rdata))
        else $error("mail changed while available");
    p_read_clears_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && rd_avail) |=> !rd_avail)
        else $error("read did not clear avail");
    p_full_write_ignored_r6: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && wr_busy) |=> $stable(mail_q))
        else $error("write to busy mailbox changed contents");
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W      = MBX_DATA_W,
    parameter int unsigned SYNC_STAGES = MBX_SYNC_NS
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              a_mb_sel,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_tx_busy,
    output logic              a_rx_avail,
    input  logic              b_mb_sel,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_tx_busy,
    output logic              b_rx_avail
);
    // Forward: port A writes, port B reads
    mbx_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_fwd (
        .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
        .wr_en(a_mb_sel & a_wr), .wdata(a_wdata), .wr_busy(a_tx_busy),
        .rd_en(b_mb_sel & b_rd), .rdata(b_rdata), .rd_avail(b_rx_avail)
    );

    // Return: port B writes, port A reads
    mbx_lane #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ret (
        .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
        .wr_en(b_mb_sel & b_wr), .wdata(b_wdata), .wr_busy(b_tx_busy),
        .rd_en(a_mb_sel & a_rd), .rdata(a_rdata), .rd_avail(a_rx_avail)
    );
endmodule

// File: tb/mbx_bypass_tb.sv
`timescale 1ns/100ps
module mbx_bypass_tb_top;
    localparam int W = 36;
    localparam int NV = 4;
    localparam logic [W-1:0] VEC [NV] = '{
        36'h0_0000_0001, 36'hF_FFFF_FFFF, 36'hA_5A5A_5A5A, 36'h1_2345_6789
    };

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic a_mb_sel = 0, a_wr = 0, a_rd = 0, b_mb_sel = 0, b_wr = 0, b_rd = 0;
    logic [W-1:0] a_wdata = '0, b_wdata = '0;
    logic [W-1:0] a_rdata, b_rdata;
    logic a_tx_busy, a_rx_avail, b_tx_busy, b_rx_avail;
    int checks = 0, errors = 0;

    always #2.0 clk_a = ~clk_a;
    always #3.5 clk_b = ~clk_b;

    mbx_bypass dut_i (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_mb_sel(a_mb_sel), .a_wr(a_wr), .a_rd(a_rd), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_tx_busy(a_tx_busy), .a_rx_avail(a_rx_avail),
        .b_mb_sel(b_mb_sel), .b_wr(b_wr), .b_rd(b_rd), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_tx_busy(b_tx_busy), .b_rx_avail(b_rx_avail)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Port A write; forward lane (R2, R3 early check)
    task automatic a_write(input logic [W-1:0] v, input logic sel, input logic exp_busy);
        @(negedge clk_a); a_mb_sel = sel; a_wr = 1; a_wdata = v;
        @(negedge clk_a); a_mb_sel = 0; a_wr = 0;
        chk("R2 a_tx_busy after write", a_tx_busy, exp_busy);
        chk("R3 b_rx_avail not yet", b_rx_avail, 0);
    endtask

    task automatic b_write(input logic [W-1:0] v);
        @(negedge clk_b); b_mb_sel = 1; b_wr = 1; b_wdata = v;
        @(negedge clk_b); b_mb_sel = 0; b_wr = 0;
        chk("R9 b_tx_busy after write", b_tx_busy, 1);
    endtask

    task automatic wait_b_avail(input string req, input logic exp);
        logic seen = ~exp;
        for (int i = 0; i < 8 && seen !== exp; i++) begin
            @(negedge clk_b); seen = b_rx_avail;
        end
        chk(req, seen, exp);
    endtask

    task automatic wait_a_avail(input string req, input logic exp);
        logic seen = ~exp;
        for (int i = 0; i < 8 && seen !== exp; i++) begin
            @(negedge clk_a); seen = a_rx_avail;
        end
        chk(req, seen, exp);
    endtask

    task automatic wait_a_busy_clear(input string req);
        logic seen = 1;
        for (int i = 0; i < 8 && seen; i++) begin
            @(negedge clk_a); seen = a_tx_busy;
        end
        chk(req, seen, 0);
    endtask

    task automatic wait_b_busy_clear(input string req);
        logic seen = 1;
        for (int i = 0; i < 8 && seen; i++) begin
            @(negedge clk_b); seen = b_tx_busy;
        end
        chk(req, seen, 0);
    endtask

    task automatic b_read(input logic [W-1:0] exp, input string req);
        @(negedge clk_b);
        chk(req, b_rdata, exp);
        b_mb_sel = 1; b_rd = 1;
        @(negedge clk_b); b_mb_sel = 0; b_rd = 0;
        chk("R5 b_rx_avail cleared by read", b_rx_avail, 0);
    endtask

    task automatic a_read(input logic [W-1:0] exp, input string req);
        @(negedge clk_a);
        chk(req, a_rdata, exp);
        a_mb_sel = 1; a_rd = 1;
        @(negedge clk_a); a_mb_sel = 0; a_rd = 0;
        chk("R9 a_rx_avail cleared by read", a_rx_avail, 0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_a);
        chk("R1 a_tx_busy in reset", a_tx_busy, 0);
        chk("R1 a_rx_avail in reset", a_rx_avail, 0);
        chk("R1 b_tx_busy in reset", b_tx_busy, 0);
        chk("R1 b_rx_avail in reset", b_rx_avail, 0);
        rst_n = 1;
        repeat (2) @(negedge clk_b);

        // Vector table: round trip in both directions
        for (int k = 0; k < NV; k++) begin
            a_write(VEC[k], 1, 1);
            wait_b_avail("R3 b_rx_avail rises", 1);
            b_read(VEC[k], "R4 forward data");
            wait_a_busy_clear("R5 a_tx_busy clears");
            b_write(~VEC[k]);
            wait_a_avail("R9 a_rx_avail rises", 1);
            a_read(~VEC[k], "R9 return data");
            wait_b_busy_clear("R9 b_tx_busy clears");
        end

        // R6: second write while busy is dropped
        a_write(36'h0_1111_1111, 1, 1);
        @(negedge clk_a); a_mb_sel = 1; a_wr = 1; a_wdata = 36'h0_2222_2222;
        @(negedge clk_a); a_mb_sel = 0; a_wr = 0;
        wait_b_avail("R6 b_rx_avail rises", 1);
        repeat (3) @(negedge clk_b);
        chk("R4 data held while available", b_rdata, 36'h0_1111_1111);
        b_read(36'h0_1111_1111, "R6 first word kept");
        wait_a_busy_clear("R6 a_tx_busy clears");

        // R7: write strobe without select
        a_write(36'h0_3333_3333, 0, 0);
        repeat (8) @(negedge clk_b);
        chk("R7 no mail without select", b_rx_avail, 0);
        chk("R7 mailbox contents kept", b_rdata, 36'h0_1111_1111);

        // R8: read strobe without select
        a_write(36'h0_4444_4444, 1, 1);
        wait_b_avail("R8 b_rx_avail rises", 1);
        @(negedge clk_b); b_rd = 1;
        @(negedge clk_b); b_rd = 0;
        chk("R8 avail kept without select", b_rx_avail, 1);
        b_read(36'h0_4444_4444, "R8 word still there");
        wait_a_busy_clear("R8 a_tx_busy clears");

        // R10: both directions at once
        fork
            begin
                a_write(36'h0_5555_5555, 1, 1);
                wait_b_avail("R10 forward avail", 1);
                b_read(36'h0_5555_5555, "R10 forward data");
            end
            begin
                @(negedge clk_b); b_mb_sel = 1; b_wr = 1; b_wdata = 36'h0_6666_6666;
                @(negedge clk_b); b_wr = 0; b_mb_sel = 0;
                wait_a_avail("R10 return avail", 1);
                a_read(36'h0_6666_6666, "R10 return data");
            end
        join
        wait_a_busy_clear("R10 a_tx_busy clears");
        wait_b_busy_clear("R10 b_tx_busy clears");

        // R1: reset with mail pending
        a_write(36'h0_7777_7777, 1, 1);
        b_write(36'h0_8888_8888);
        repeat (6) @(negedge clk_b);
        rst_n = 0;
        #1;
        chk("R1 a_tx_busy after reset", a_tx_busy, 0);
        chk("R1 b_tx_busy after reset", b_tx_busy, 0);
        chk("R1 a_rx_avail after reset", a_rx_avail, 0);
        chk("R1 b_rx_avail after reset", b_rx_avail, 0);
        @(negedge clk_b); rst_n = 1;
        repeat (6) @(negedge clk_b);
        chk("R1 no stale mail after reset", b_rx_avail, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule